// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Unit

This block gives the two processors that share a dual-ported memory a small message space of their own. Each port has a mailbox-select input. While it is low, the low address bits and the data bus of that port reach a set of 16-bit mailboxes instead of the memory array. Half of the mailboxes carry messages from the left port to the right port, and the other half carry messages the other way. Each port also has its own mask register.

When one port writes a message into a mailbox that the other port receives, the receiver's flag for that mailbox is set. The receiver's active-low interrupt falls as soon as any of its flags is set and that flag's mask bit is enabled. Reading the mailbox from the receiving side clears the flag. Both ports run on one clock, and read data appears one cycle after the read.

Top module: `mbx_irq_unit`

## Requirements
- R1: After reset all mailboxes, flags and mask registers are zero, both interrupt outputs are high, and a read of any offset returns zero.
- R2: A port reaches the mailbox space only in a cycle where its enable is high and its select is low. Otherwise its writes change nothing, and its read data in the next cycle is zero.
- R3: Offsets 0 to 3 are the left-to-right mailboxes and offsets 4 to 7 are the right-to-left mailboxes. Either port can read any mailbox. The value of a read appears on that port's read data one clock after the read cycle.
- R4: Write-enable bit 0 writes data bits 7:0 and bit 1 writes bits 15:8. A write with both bits low changes nothing and sets no flag.
- R5: A left write with any byte enable to offset i (i = 0..3) sets right flag i. A right write to offset 4+i sets left flag i. A write by the receiving port stores its data but sets no flag.
- R6: A read of offset i by the right port clears right flag i. A read of offset 4+i by the left port clears left flag i. A read by the sending port clears nothing.
- R7: Offset 8 is the accessing port's own mask register, held in data bits 3:0. Mask bit i = 1 enables flag i. It is written only when write-enable bit 0 is set, and it reads back with bits 15:4 zero.
- R8: A port's interrupt output is low exactly when at least one of its flags is set with the matching mask bit set.
- R9: Offsets 9 to 63 read as zero, and writes to them change nothing.
- R10: When one port reads a mailbox in the same cycle the other port writes it, the read returns the previous contents and the new data is stored. A flag that is set and cleared in the same cycle ends up set.
- R11: When both ports write the same mailbox in one cycle, each byte enabled by the left port takes the left data. Each byte enabled only by the right port takes the right data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_en | input | 1 | Left port access strobe |
| l_sel_n | input | 1 | Left port mailbox select, low selects the mailbox space |
| l_wr | input | 1 | Left port: 1 writes, 0 reads |
| l_addr | input | 6 | Left port mailbox offset |
| l_be | input | 2 | Left port byte write enables |
| l_wdata | input | 16 | Left port write data |
| l_rdata | output | 16 | Left port read data, one cycle after the read |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_en | input | 1 | Right port access strobe |
| r_sel_n | input | 1 | Right port mailbox select, low selects the mailbox space |
| r_wr | input | 1 | Right port: 1 writes, 0 reads |
| r_addr | input | 6 | Right port mailbox offset |
| r_be | input | 2 | Right port byte write enables |
| r_wdata | input | 16 | Right port write data |
| r_rdata | output | 16 | Right port read data, one cycle after the read |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The bench builds the block with its default parameters: 16-bit data, a 6-bit offset and four mailboxes per direction. With these values the whole offset space of 64 entries can be swept from both ports for writes and reads. All four byte-enable codes and all sixteen mask values can be applied to every flag. Same-cycle collisions between the ports, where one reads while the other writes or both write, are driven cycle by cycle against a model that the bench updates arithmetically from the requirements.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Region of the mailbox space that an offset falls in.
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_BOX  = 2'd1,
    RGN_MASK = 2'd2
  } mbx_region_e;

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBOX   = 4,
  parameter int BE_W   = 2
) (
  input  logic                        en,
  input  logic                        sel_n,
  input  logic                        wr,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BE_W-1:0]             be,
  output logic [2*NBOX-1:0]           wr_box,
  output logic [2*NBOX-1:0]           rd_box,
  output logic                        mask_wr,
  output logic                        mask_rd,
  output logic [$clog2(2*NBOX)-1:0]   idx
);

  localparam int NW    = 2 * NBOX;
  localparam int IDX_W = $clog2(NW);
  localparam logic [ADDR_W-1:0] MASK_OFS = ADDR_W'(NW);

  logic        act;
  mbx_region_e region;

  assign act = en & ~sel_n;

  always_comb begin
    region = RGN_NONE;
    if (addr < MASK_OFS)       region = RGN_BOX;
    else if (addr == MASK_OFS) region = RGN_MASK;
  end

  genvar w;
  generate
    for (w = 0; w < NW; w++) begin : g_hit
      logic hit;
      assign hit       = act && (region == RGN_BOX) && (addr == ADDR_W'(w));
      assign wr_box[w] = hit & wr & (|be);
      assign rd_box[w] = hit & ~wr;
    end
  endgenerate

  assign mask_wr = act && (region == RGN_MASK) && wr && be[0];
  assign mask_rd = act && (region == RGN_MASK) && !wr;
  assign idx     = addr[IDX_W-1:0];

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int DATA_W = 16,
  parameter int NW     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NW-1:0]                l_we,
  input  logic [NW-1:0]                r_we,
  input  logic [DATA_W/8-1:0]          l_be,
  input  logic [DATA_W/8-1:0]          r_be,
  input  logic [DATA_W-1:0]            l_wdata,
  input  logic [DATA_W-1:0]            r_wdata,
  output logic [NW-1:0][DATA_W-1:0]    box_q
);

  localparam int BE_W = DATA_W / 8;

  logic [NW-1:0][DATA_W-1:0] box_d;
  logic                      any_we;

  assign any_we = |(l_we | r_we);

  // Right bytes first, left bytes after: left wins on a shared byte.
  always_comb begin
    box_d = box_q;
    for (int w = 0; w < NW; w++) begin
      for (int b = 0; b < BE_W; b++) begin
        if (r_we[w] && r_be[b]) box_d[w][b*8 +: 8] = r_wdata[b*8 +: 8];
        if (l_we[w] && l_be[b]) box_d[w][b*8 +: 8] = l_wdata[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      box_q <= '0;
    else if (any_we) box_q <= box_d;
  end

  // Untouched storage holds its value.
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_we) |=> $stable(box_q));

  genvar gw, gb;
  generate
    for (gw = 0; gw < NW; gw++) begin : g_chk_w
      for (gb = 0; gb < BE_W; gb++) begin : g_chk_b
        assert_left_byte_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
          (l_we[gw] && l_be[gb]) |=> (box_q[gw][gb*8 +: 8] == $past(l_wdata[gb*8 +: 8])));
      end
    end
  endgenerate

endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
  parameter int NBOX = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0][NBOX-1:0]  set,
  input  logic [1:0][NBOX-1:0]  clr,
  input  logic [1:0]            mask_we,
  input  logic [1:0][NBOX-1:0]  mask_wd,
  output logic [1:0][NBOX-1:0]  flag_q,
  output logic [1:0][NBOX-1:0]  mask_q,
  output logic [1:0]            irq_n
);

  genvar p;
  generate
    for (p = 0; p < 2; p++) begin : g_port
      logic [NBOX-1:0] flag_d;
      logic [NBOX-1:0] mask_d;
      logic            flag_en;

      // A set in the same cycle as a clear leaves the flag set.
      assign flag_d  = (flag_q[p] & ~clr[p]) | set[p];
      assign flag_en = |(set[p] | clr[p]);
      assign mask_d  = mask_wd[p];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q[p] <= '0;
        else if (flag_en) flag_q[p] <= flag_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mask_q[p] <= '0;
        else if (mask_we[p]) mask_q[p] <= mask_d;
      end

      assign irq_n[p] = ~|(flag_q[p] & mask_q[p]);

      assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set[p] != '0) |=> ((flag_q[p] & $past(set[p])) == $past(set[p])));

      assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr[p] & ~set[p]) != '0) |=> ((flag_q[p] & $past(clr[p] & ~set[p])) == '0));

      assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_we[p]) |=> $stable(mask_q[p]));

      assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n[p]) |-> ((flag_q[p] != '0) && (mask_q[p] != '0)));
    end
  endgenerate

endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int NBOX   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_sel_n,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W/8-1:0] l_be,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_en,
  input  logic              r_sel_n,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W/8-1:0] r_be,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);

  localparam int NW    = 2 * NBOX;
  localparam int BE_W  = DATA_W / 8;
  localparam int IDX_W = $clog2(NW);

  logic rst_s;

  mbx_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s)
  );

  // Port index 0 is left, 1 is right.
  logic [1:0]                p_en, p_sel_n, p_wr;
  logic [1:0][ADDR_W-1:0]    p_addr;
  logic [1:0][BE_W-1:0]      p_be;
  logic [1:0][DATA_W-1:0]    p_wdata;
  logic [1:0][NW-1:0]        wr_box, rd_box;
  logic [1:0]                mask_wr, mask_rd;
  logic [1:0][IDX_W-1:0]     idx;
  logic [1:0][DATA_W-1:0]    rd_d, rd_q;
  logic [1:0][NBOX-1:0]      set_v, clr_v, mask_wd, flag_q, mask_q;
  logic [1:0]                irq_n;
  logic [NW-1:0][DATA_W-1:0] box_q;

  assign p_en    = {r_en, l_en};
  assign p_sel_n = {r_sel_n, l_sel_n};
  assign p_wr    = {r_wr, l_wr};
  assign p_addr  = {r_addr, l_addr};
  assign p_be    = {r_be, l_be};
  assign p_wdata = {r_wdata, l_wdata};

  genvar p;
  generate
    for (p = 0; p < 2; p++) begin : g_port
      mbx_decode #(
        .ADDR_W (ADDR_W),
        .NBOX   (NBOX),
        .BE_W   (BE_W)
      ) u_dec (
        .en      (p_en[p]),
        .sel_n   (p_sel_n[p]),
        .wr      (p_wr[p]),
        .addr    (p_addr[p]),
        .be      (p_be[p]),
        .wr_box  (wr_box[p]),
        .rd_box  (rd_box[p]),
        .mask_wr (mask_wr[p]),
        .mask_rd (mask_rd[p]),
        .idx     (idx[p])
      );

      always_comb begin
        rd_d[p] = '0;
        if (|rd_box[p])      rd_d[p] = box_q[idx[p]];
        else if (mask_rd[p]) rd_d[p] = {{(DATA_W-NBOX){1'b0}}, mask_q[p]};
      end

      always_ff @(posedge clk or negedge rst_s) begin
        if (!rst_s) rd_q[p] <= '0;
        else        rd_q[p] <= rd_d[p];
      end

      assign mask_wd[p] = p_wdata[p][NBOX-1:0];

      assert_onehot_access_R3: assert property (@(posedge clk) disable iff (!rst_s)
        $onehot0(wr_box[p]) && $onehot0(rd_box[p]));

      assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_s)
        (!p_en[p] || p_sel_n[p]) |=> (rd_q[p] == '0));
    end
  endgenerate

  // Receiver mapping: left owns offsets NBOX..NW-1, right owns 0..NBOX-1.
  assign set_v[0] = wr_box[1][NW-1:NBOX];
  assign clr_v[0] = rd_box[0][NW-1:NBOX];
  assign set_v[1] = wr_box[0][NBOX-1:0];
  assign clr_v[1] = rd_box[1][NBOX-1:0];

  mbx_store #(
    .DATA_W (DATA_W),
    .NW     (NW)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_s),
    .l_we    (wr_box[0]),
    .r_we    (wr_box[1]),
    .l_be    (l_be),
    .r_be    (r_be),
    .l_wdata (l_wdata),
    .r_wdata (r_wdata),
    .box_q   (box_q)
  );

  mbx_flags #(
    .NBOX (NBOX)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_s),
    .set     (set_v),
    .clr     (clr_v),
    .mask_we (mask_wr),
    .mask_wd (mask_wd),
    .flag_q  (flag_q),
    .mask_q  (mask_q),
    .irq_n   (irq_n)
  );

  assign l_rdata = rd_q[0];
  assign r_rdata = rd_q[1];
  assign l_irq_n = irq_n[0];
  assign r_irq_n = irq_n[1];

endmodule

// File: tb/tb_mbx_irq_unit.sv
`timescale 1ns/1ps
module tb_mbx_irq_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        l_en, l_sel_n, l_wr, r_en, r_sel_n, r_wr;
  logic [5:0]  l_addr, r_addr;
  logic [1:0]  l_be, r_be;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic        l_irq_n, r_irq_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Bench-side model of the mailbox state.
  logic [15:0] m_box [8];
  logic [3:0]  m_fl, m_fr, m_ml, m_mr;

  always #4 clk = ~clk;

  mbx_irq_unit dut (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_sel_n(l_sel_n), .l_wr(l_wr), .l_addr(l_addr), .l_be(l_be),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_en(r_en), .r_sel_n(r_sel_n), .r_wr(r_wr), .r_addr(r_addr), .r_be(r_be),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  task automatic setl(input logic en, input logic sn, input logic wr,
                      input logic [5:0] a, input logic [1:0] be, input logic [15:0] d);
    l_en = en; l_sel_n = sn; l_wr = wr; l_addr = a; l_be = be; l_wdata = d;
  endtask

  task automatic setr(input logic en, input logic sn, input logic wr,
                      input logic [5:0] a, input logic [1:0] be, input logic [15:0] d);
    r_en = en; r_sel_n = sn; r_wr = wr; r_addr = a; r_be = be; r_wdata = d;
  endtask

  task automatic idle();
    setl(1'b0, 1'b1, 1'b0, 6'd0, 2'b00, 16'h0);
    setr(1'b0, 1'b1, 1'b0, 6'd0, 2'b00, 16'h0);
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One clock with the currently driven inputs; model updated, outputs checked.
  task automatic tick(input string tag);
    logic la, ra;
    logic [15:0] el, er;
    logic [3:0] sl, cl, sr, cr;
    la = l_en && !l_sel_n;
    ra = r_en && !r_sel_n;
    el = 16'h0; er = 16'h0;
    if (la && !l_wr) begin
      if (l_addr < 6'd8) el = m_box[l_addr[2:0]];
      else if (l_addr == 6'd8) el = {12'h0, m_ml};
    end
    if (ra && !r_wr) begin
      if (r_addr < 6'd8) er = m_box[r_addr[2:0]];
      else if (r_addr == 6'd8) er = {12'h0, m_mr};
    end
    for (int b = 0; b < 2; b++) begin
      if (ra && r_wr && r_addr < 6'd8 && r_be[b]) m_box[r_addr[2:0]][b*8 +: 8] = r_wdata[b*8 +: 8];
      if (la && l_wr && l_addr < 6'd8 && l_be[b]) m_box[l_addr[2:0]][b*8 +: 8] = l_wdata[b*8 +: 8];
    end
    if (la && l_wr && l_addr == 6'd8 && l_be[0]) m_ml = l_wdata[3:0];
    if (ra && r_wr && r_addr == 6'd8 && r_be[0]) m_mr = r_wdata[3:0];
    sl = 4'h0; cl = 4'h0; sr = 4'h0; cr = 4'h0;
    if (la && l_wr && l_addr < 6'd4 && l_be != 2'b00) sr[l_addr[1:0]] = 1'b1;
    if (ra && !r_wr && r_addr < 6'd4) cr[r_addr[1:0]] = 1'b1;
    if (ra && r_wr && r_addr >= 6'd4 && r_addr < 6'd8 && r_be != 2'b00) sl[r_addr[1:0]] = 1'b1;
    if (la && !l_wr && l_addr >= 6'd4 && l_addr < 6'd8) cl[l_addr[1:0]] = 1'b1;
    m_fr = (m_fr & ~cr) | sr;
    m_fl = (m_fl & ~cl) | sl;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "l_rdata", l_rdata, el);
    chk(tag, "r_rdata", r_rdata, er);
    chk(tag, "l_irq_n", {15'h0, l_irq_n}, {15'h0, ~|(m_fl & m_ml)});
    chk(tag, "r_irq_n", {15'h0, r_irq_n}, {15'h0, ~|(m_fr & m_mr)});
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_box[i] = 16'h0;
    m_fl = 4'h0; m_fr = 4'h0; m_ml = 4'h0; m_mr = 4'h0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state, every defined offset reads zero from both ports
    tick("R1");
    for (int a = 0; a < 9; a++) begin
      setl(1'b1, 1'b0, 1'b0, 6'(a), 2'b00, 16'h0);
      setr(1'b1, 1'b0, 1'b0, 6'(a), 2'b00, 16'h0);
      tick("R1");
    end

    // R3 / R9: left write sweep over all offsets, then read back from both ports
    for (int a = 0; a < 64; a++) begin
      setl(1'b1, 1'b0, 1'b1, 6'(a), 2'b11, 16'h3C00 + 16'(a * 16'h0107));
      tick(a < 8 ? "R3" : "R9");
    end
    for (int a = 0; a < 64; a++) begin
      setl(1'b1, 1'b0, 1'b0, 6'(a), 2'b00, 16'h0);
      setr(1'b1, 1'b0, 1'b0, 6'(63 - a), 2'b00, 16'h0);
      tick(a < 9 ? "R3" : "R9");
    end
    // right write sweep, read back
    for (int a = 0; a < 64; a++) begin
      setr(1'b1, 1'b0, 1'b1, 6'(a), 2'b11, 16'(a * 16'h0B0D) ^ 16'h5A5A);
      tick(a < 8 ? "R3" : "R9");
    end
    for (int a = 0; a < 64; a++) begin
      setl(1'b1, 1'b0, 1'b0, 6'(a), 2'b00, 16'h0);
      setr(1'b1, 1'b0, 1'b0, 6'(a), 2'b00, 16'h0);
      tick(a < 9 ? "R3" : "R9");
    end

    // R2: writes with select high or enable low do nothing
    for (int a = 0; a < 9; a++) begin
      setl(1'b1, 1'b1, 1'b1, 6'(a), 2'b11, 16'hFFFF);
      setr(1'b0, 1'b0, 1'b1, 6'(a), 2'b11, 16'hEEEE);
      tick("R2");
      setl(1'b0, 1'b0, 1'b1, 6'(a), 2'b11, 16'hDDDD);
      setr(1'b1, 1'b1, 1'b1, 6'(a), 2'b11, 16'hCCCC);
      tick("R2");
      setl(1'b1, 1'b1, 1'b0, 6'(a), 2'b00, 16'h0);
      setr(1'b1, 1'b1, 1'b0, 6'(a), 2'b00, 16'h0);
      tick("R2");
    end
    for (int a = 0; a < 9; a++) begin
      setl(1'b1, 1'b0, 1'b0, 6'(a), 2'b00, 16'h0);
      setr(1'b1, 1'b0, 1'b0, 6'(a), 2'b00, 16'h0);
      tick("R2");
    end

    // R4: each byte-enable code on box 2, read back from the right
    for (int be = 0; be < 4; be++) begin
      setl(1'b1, 1'b0, 1'b1, 6'd2, 2'(be), 16'(16'h1111 * (be + 5)));
      tick("R4");
      setr(1'b1, 1'b0, 1'b0, 6'd2, 2'b00, 16'h0);
      tick("R4");
    end

    // R7: enable all flags on both ports
    setl(1'b1, 1'b0, 1'b1, 6'd8, 2'b01, 16'hFFFF);
    setr(1'b1, 1'b0, 1'b1, 6'd8, 2'b01, 16'h000F);
    tick("R7");

    // R5 / R6 / R8: per-flag set and clear in both directions
    for (int i = 0; i < 4; i++) begin
      setr(1'b1, 1'b0, 1'b1, 6'(i), 2'b11, 16'h0A00 + 16'(i));
      tick("R5");
      setl(1'b1, 1'b0, 1'b1, 6'(i), 2'b10, 16'hB100 + 16'(i));
      tick("R5/R8");
      setl(1'b1, 1'b0, 1'b0, 6'(i), 2'b00, 16'h0);
      tick("R6");
      setr(1'b1, 1'b0, 1'b0, 6'(i), 2'b00, 16'h0);
      tick("R6/R8");
      setl(1'b1, 1'b0, 1'b1, 6'(4 + i), 2'b11, 16'h0C00 + 16'(i));
      tick("R5");
      setr(1'b1, 1'b0, 1'b1, 6'(4 + i), 2'b01, 16'hD200 + 16'(i));
      tick("R5/R8");
      setr(1'b1, 1'b0, 1'b0, 6'(4 + i), 2'b00, 16'h0);
      tick("R6");
      setl(1'b1, 1'b0, 1'b0, 6'(4 + i), 2'b00, 16'h0);
      tick("R6/R8");
    end

    // R7 / R8: raise every flag, then sweep all mask values
    for (int i = 0; i < 4; i++) begin
      setl(1'b1, 1'b0, 1'b1, 6'(i), 2'b11, 16'h7000 + 16'(i));
      setr(1'b1, 1'b0, 1'b1, 6'(4 + i), 2'b11, 16'h8000 + 16'(i));
      tick("R5");
    end
    for (int m = 0; m < 16; m++) begin
      setl(1'b1, 1'b0, 1'b1, 6'd8, 2'b01, 16'hFFF0 | 16'(m));
      setr(1'b1, 1'b0, 1'b1, 6'd8, 2'b01, 16'(15 - m));
      tick("R7/R8");
      setl(1'b1, 1'b0, 1'b1, 6'd8, 2'b10, 16'h000F);
      setr(1'b1, 1'b0, 1'b1, 6'd8, 2'b10, 16'h000F);
      tick("R7");
      setl(1'b1, 1'b0, 1'b0, 6'd8, 2'b00, 16'h0);
      setr(1'b1, 1'b0, 1'b0, 6'd8, 2'b00, 16'h0);
      tick("R7");
    end
    setl(1'b1, 1'b0, 1'b1, 6'd8, 2'b01, 16'h000F);
    setr(1'b1, 1'b0, 1'b1, 6'd8, 2'b01, 16'h000F);
    tick("R7");

    // R10: read and write of one mailbox in one cycle, set beats clear
    setr(1'b1, 1'b0, 1'b0, 6'd1, 2'b00, 16'h0);
    tick("R6");
    setl(1'b1, 1'b0, 1'b1, 6'd1, 2'b11, 16'h9ABC);
    setr(1'b1, 1'b0, 1'b0, 6'd1, 2'b00, 16'h0);
    tick("R10");
    setr(1'b1, 1'b0, 1'b0, 6'd1, 2'b00, 16'h0);
    tick("R10");
    setl(1'b1, 1'b0, 1'b0, 6'd6, 2'b00, 16'h0);
    tick("R6");
    setr(1'b1, 1'b0, 1'b1, 6'd6, 2'b11, 16'h4321);
    setl(1'b1, 1'b0, 1'b0, 6'd6, 2'b00, 16'h0);
    tick("R10");
    setl(1'b1, 1'b0, 1'b0, 6'd6, 2'b00, 16'h0);
    tick("R10");

    // R11: both ports write one mailbox in one cycle
    for (int lb = 0; lb < 4; lb++) begin
      setl(1'b1, 1'b0, 1'b1, 6'd3, 2'(lb), 16'hA1B2);
      setr(1'b1, 1'b0, 1'b1, 6'd3, 2'b11, 16'hC3D4);
      tick("R11");
      setr(1'b1, 1'b0, 1'b0, 6'd3, 2'b00, 16'h0);
      tick("R11");
      setl(1'b1, 1'b0, 1'b1, 6'd5, 2'(lb), 16'h1357);
      setr(1'b1, 1'b0, 1'b1, 6'd5, 2'(3 - lb), 16'h2468);
      tick("R11");
      setl(1'b1, 1'b0, 1'b0, 6'd5, 2'b00, 16'h0);
      tick("R11");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule